// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the memory traffic a processor core needs when it takes an interrupt and when it runs the return-from-interrupt instruction. On an entry request it captures an 8-bit vector type together with the live flag word, code segment and instruction pointer. It then saves those three words on a stack that grows downward and fetches the handler's new instruction pointer and code segment from a vector table in the lowest kilobyte of the address space. The interrupt-enable and trap bits are cleared in the flag word it hands back.

On a return request it reads the three saved words back in reverse order and restores them. All traffic goes over a plain 16-bit word interface with a byte address, separate read and write strobes and a ready input that can stall any access. The core sees `busy` while a sequence runs and a single-cycle `done` when the new state is valid. Choosing between interrupt sources and decoding instructions are handled elsewhere.

Top module: `intr_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_rd` and `mem_wr` are 0 and `sp_out` equals the parameter SP_RESET.
- R2: An entry writes three words in this order: flags, then CS, then IP. Before each write the stack pointer drops by 2, and the write goes to the new stack pointer. After an entry `sp_out` is 6 below its earlier value.
- R3: After the pushes, an entry reads the new IP from byte address type×4. With an 8-bit type this always lies within 0x000–0x3FF.
- R4: Next, an entry reads the new CS from byte address type×4+2. `ip_out` and `cs_out` then hold these two words.
- R5: At the end of an entry, `flags_out` equals the captured flags with bit 9 (interrupt enable) and bit 8 (trap) forced to 0. All other bits are unchanged.
- R6: A return reads IP from the stack pointer, then CS from the stack pointer plus 2, then flags from the stack pointer plus 4. It raises the stack pointer by 2 after each read, and the three words appear on `ip_out`, `cs_out` and `flags_out`. Entries and returns nest in last-in, first-out order.
- R7: A strobe holds its address and write data until `mem_ready` is seen high at a clock edge. Each accepted access happens exactly once.
- R8: `done` is a one-cycle pulse in the cycle after the last access is accepted. `busy` is high from the cycle after a request until that pulse, and it is low while `done` is high.
- R9: Requests that arrive while `busy` is high are ignored. If both requests arrive together while idle, the entry is taken.
- R10: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Start an interrupt entry |
| ret_req | input | 1 | Start an interrupt return |
| vec_type | input | 8 | Vector type number |
| flags_in | input | 16 | Flag word to save |
| cs_in | input | 16 | Return code segment to save |
| ip_in | input | 16 | Return instruction pointer to save |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, outputs valid |
| flags_out | output | 16 | New or restored flag word |
| cs_out | output | 16 | New or restored code segment |
| ip_out | output | 16 | New or restored instruction pointer |
| sp_out | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Byte address of the word access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_ready | input | 1 | Access completes at this edge |

## Verification
The bench builds the block with 16-bit data and addresses and an 8-bit type, which puts all 256 vector types within reach. That includes type 255, whose CS word sits at the last word of the table, 0x3FE. SP_RESET is overridden to 0x1000, so forty levels of nested entries stay well clear of the vector table while returns unwind in last-in, first-out order. Random ready stalls, including long stretches of low ready, test the hold-until-ready behaviour on every access.

// File: rtl/intr_seq.sv
module intr_seq #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int TW = 8,
  parameter int IF_POS = 9,
  parameter int TF_POS = 8,
  parameter logic [AW-1:0] SP_RESET = 16'h0800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_req,
  input  logic          ret_req,
  input  logic [TW-1:0] vec_type,
  input  logic [DW-1:0] flags_in,
  input  logic [DW-1:0] cs_in,
  input  logic [DW-1:0] ip_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] flags_out,
  output logic [DW-1:0] cs_out,
  output logic [DW-1:0] ip_out,
  output logic [AW-1:0] sp_out,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          mem_ready
);
  localparam int PAD = AW - TW - 2;
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] KEEP = ~((ONE << IF_POS) | (ONE << TF_POS));
  localparam logic [AW-1:0] STEP = {{(AW-2){1'b0}}, 2'd2};

  typedef enum logic [3:0] {
    S_IDLE, S_PF, S_PC, S_PI, S_VI, S_VC, S_RI, S_RC, S_RF
  } st_t;

  st_t           state;
  logic [TW-1:0] typ;
  logic [DW-1:0] fl_q, cs_q, ip_q;
  logic          ent_q;
  logic [AW-1:0] vbase;

  assign busy   = (state != S_IDLE);
  assign mem_wr = (state == S_PF) || (state == S_PC) || (state == S_PI);
  assign mem_rd = (state == S_VI) || (state == S_VC) || (state == S_RI) ||
                  (state == S_RC) || (state == S_RF);
  assign vbase  = {{PAD{1'b0}}, typ, 2'b00};

  always_comb begin
    mem_addr  = sp_out;
    mem_wdata = '0;
    case (state)
      S_PF:    begin mem_addr = sp_out - STEP; mem_wdata = fl_q; end
      S_PC:    begin mem_addr = sp_out - STEP; mem_wdata = cs_q; end
      S_PI:    begin mem_addr = sp_out - STEP; mem_wdata = ip_q; end
      S_VI:    mem_addr = vbase;
      S_VC:    mem_addr = vbase + STEP;
      default: mem_addr = sp_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sp_out    <= SP_RESET;
      done      <= 1'b0;
      typ       <= '0;
      fl_q      <= '0;
      cs_q      <= '0;
      ip_q      <= '0;
      ent_q     <= 1'b0;
      flags_out <= '0;
      cs_out    <= '0;
      ip_out    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE:
          if (entry_req) begin
            typ   <= vec_type;
            fl_q  <= flags_in;
            cs_q  <= cs_in;
            ip_q  <= ip_in;
            ent_q <= 1'b1;
            state <= S_PF;
          end else if (ret_req) begin
            ent_q <= 1'b0;
            state <= S_RI;
          end
        S_PF: if (mem_ready) begin sp_out <= sp_out - STEP; state <= S_PC; end
        S_PC: if (mem_ready) begin sp_out <= sp_out - STEP; state <= S_PI; end
        S_PI: if (mem_ready) begin sp_out <= sp_out - STEP; state <= S_VI; end
        S_VI: if (mem_ready) begin ip_out <= mem_rdata; state <= S_VC; end
        S_VC:
          if (mem_ready) begin
            cs_out    <= mem_rdata;
            flags_out <= fl_q & KEEP;
            done      <= 1'b1;
            state     <= S_IDLE;
          end
        S_RI: if (mem_ready) begin ip_out <= mem_rdata; sp_out <= sp_out + STEP; state <= S_RC; end
        S_RC: if (mem_ready) begin cs_out <= mem_rdata; sp_out <= sp_out + STEP; state <= S_RF; end
        S_RF:
          if (mem_ready) begin
            flags_out <= mem_rdata;
            sp_out    <= sp_out + STEP;
            done      <= 1'b1;
            state     <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rd) && $stable(mem_wr)));

  assert_sp_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ready) |=> (sp_out == $past(sp_out) - STEP));

  assert_sp_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ready && !ent_q) |=> (sp_out == $past(sp_out) + STEP));

  assert_flags_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ent_q) |-> (!flags_out[IF_POS] && !flags_out[TF_POS]));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_vec_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && ent_q) |-> (mem_addr < 16'h0400));
endmodule

// File: tb/sim_intr_seq.sv
module sim_intr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_req = 1'b0, ret_req = 1'b0;
  logic [7:0]  vec_type = '0;
  logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] flags_out, cs_out, ip_out, sp_out, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  localparam logic [15:0] SP0 = 16'h1000;

  intr_seq #(.SP_RESET(SP0)) u0 (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .ret_req(ret_req),
    .vec_type(vec_type), .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in),
    .busy(busy), .done(done), .flags_out(flags_out), .cs_out(cs_out),
    .ip_out(ip_out), .sp_out(sp_out), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;
  int slow = 0;

  logic [15:0] mem [int];
  logic [15:0] lg_addr [0:15];
  logic [15:0] lg_data [0:15];
  bit          lg_wr   [0:15];
  int          nlog = 0;

  logic [15:0] stk_f [0:63];
  logic [15:0] stk_c [0:63];
  logic [15:0] stk_i [0:63];
  int          depth = 0;
  logic [15:0] exp_sp = SP0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_addr(input logic [7:0] t);
    return {6'd0, t, 2'b00};
  endfunction

  function automatic logic [15:0] clr_flags(input logic [15:0] f);
    return f & ~16'h0300;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) mem_ready = 1'b0;
    else begin
      mem_ready = (slow != 0) ? (($urandom % 6) == 0) : (($urandom % 3) != 0);
      if (mem_rd) mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
      if (mem_ready && (mem_rd || mem_wr) && nlog < 16) begin
        lg_addr[nlog] = mem_addr;
        lg_data[nlog] = mem_wr ? mem_wdata : mem_rdata;
        lg_wr[nlog]   = mem_wr;
        nlog++;
        if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic wait_done(input bit poke);
    int n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin
        chk(busy == 1'b1, "R8", "busy during sequence", 32'(busy), 32'd1);
        entry_req = 1'b1; ret_req = 1'b1; vec_type = 8'h5A;
        @(negedge clk);
        entry_req = 1'b0; ret_req = 1'b0;
      end
    end
    chk(busy == 1'b0, "R8", "busy low at done", 32'(busy), 32'd0);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", 32'(done), 32'd0);
    chk(!busy && !mem_rd && !mem_wr, "R9", "stays idle after done",
        {mem_rd, mem_wr, busy}, 32'd0);
  endtask

  task automatic do_entry(input logic [7:0] t, input logic [15:0] f,
                          input logic [15:0] c, input logic [15:0] i,
                          input bit both, input bit poke);
    vec_type = t; flags_in = f; cs_in = c; ip_in = i;
    entry_req = 1'b1; ret_req = both;
    nlog = 0;
    @(negedge clk);
    entry_req = 1'b0; ret_req = 1'b0;
    flags_in = ~f; cs_in = ~c; ip_in = ~i; vec_type = ~t;
    wait_done(poke);
    chk(nlog == 5, "R7", "entry access count", 32'(nlog), 32'd5);
    chk(lg_wr[0] && lg_addr[0] == exp_sp - 16'd2 && lg_data[0] == f, "R2", "flags push",
        {lg_addr[0], lg_data[0]}, {exp_sp - 16'd2, f});
    chk(lg_wr[1] && lg_addr[1] == exp_sp - 16'd4 && lg_data[1] == c, "R2", "cs push",
        {lg_addr[1], lg_data[1]}, {exp_sp - 16'd4, c});
    chk(lg_wr[2] && lg_addr[2] == exp_sp - 16'd6 && lg_data[2] == i, "R2", "ip push",
        {lg_addr[2], lg_data[2]}, {exp_sp - 16'd6, i});
    chk(!lg_wr[3] && lg_addr[3] == vec_addr(t), "R3", "ip vector read",
        32'(lg_addr[3]), 32'(vec_addr(t)));
    chk(!lg_wr[4] && lg_addr[4] == vec_addr(t) + 16'd2, "R4", "cs vector read",
        32'(lg_addr[4]), 32'(vec_addr(t) + 16'd2));
    chk(ip_out == mem[int'(vec_addr(t))] && cs_out == mem[int'(vec_addr(t)) + 2], "R4",
        "new cs:ip", {cs_out, ip_out},
        {mem[int'(vec_addr(t)) + 2], mem[int'(vec_addr(t))]});
    chk(flags_out == clr_flags(f), "R5", "flags IF/TF cleared", 32'(flags_out),
        32'(clr_flags(f)));
    exp_sp = exp_sp - 16'd6;
    chk(sp_out == exp_sp, "R2", "sp after entry", 32'(sp_out), 32'(exp_sp));
    stk_f[depth] = f; stk_c[depth] = c; stk_i[depth] = i;
    depth++;
    after_done();
  endtask

  task automatic do_return(input bit poke);
    ret_req = 1'b1;
    nlog = 0;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done(poke);
    depth--;
    chk(nlog == 3, "R7", "return access count", 32'(nlog), 32'd3);
    chk(!lg_wr[0] && lg_addr[0] == exp_sp && !lg_wr[1] && lg_addr[1] == exp_sp + 16'd2 &&
        !lg_wr[2] && lg_addr[2] == exp_sp + 16'd4, "R6", "pop addresses",
        32'(lg_addr[0]), 32'(exp_sp));
    chk(ip_out == stk_i[depth] && cs_out == stk_c[depth], "R6", "restored cs:ip",
        {cs_out, ip_out}, {stk_c[depth], stk_i[depth]});
    chk(flags_out == stk_f[depth], "R6", "restored flags", 32'(flags_out),
        32'(stk_f[depth]));
    exp_sp = exp_sp + 16'd6;
    chk(sp_out == exp_sp, "R6", "sp after return", 32'(sp_out), 32'(exp_sp));
    after_done();
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int t = 0; t < 256; t++) begin
      mem[t * 4]     = 16'($urandom);
      mem[t * 4 + 2] = 16'($urandom);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1", "idle in reset",
        {busy, done, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp_out == SP0, "R1", "sp reset value", 32'(sp_out), 32'(SP0));
    chk(!busy && !done && !mem_rd && !mem_wr, "R1", "idle after reset",
        {busy, done, mem_rd, mem_wr}, 32'd0);

    do_entry(8'd0, 16'hFFFF, 16'h1234, 16'h5678, 1'b0, 1'b0);
    do_entry(8'd255, 16'h0300, 16'hABCD, 16'hEF01, 1'b1, 1'b0);
    do_return(1'b0);
    do_return(1'b1);
    do_entry(8'd2, 16'h0F0F, 16'h0000, 16'hFFFE, 1'b0, 1'b1);
    do_return(1'b0);

    slow = 1;
    do_entry(8'd4, 16'h0200, 16'h4444, 16'h5555, 1'b0, 1'b0);
    do_return(1'b0);
    slow = 0;

    for (int k = 0; k < 120; k++) begin
      if (depth < 40 && (depth == 0 || ($urandom % 2) == 0))
        do_entry(8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                 1'(($urandom % 4) == 0), 1'(($urandom % 5) == 0));
      else
        do_return(1'(($urandom % 5) == 0));
    end
    while (depth > 0) do_return(1'b0);
    chk(sp_out == SP0, "R6", "stack fully unwound", 32'(sp_out), 32'(SP0));
    finish_run();
  end
endmodule